// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block stands between a group of 32 lanes and a scratchpad of 32 banks. Each bank is one 32-bit word wide. A single request carries a word index for every lane, a lane enable mask, a direction flag and per-lane write data. The block assigns each word to a bank using the low bits of its index. It then issues the request as a series of passes. In each pass a bank serves exactly one distinct word, and every lane that wants that word is served in the same pass. For a read, the word is broadcast to all of those lanes. The number of passes is therefore the largest count of distinct words that any single bank must deliver.

A small controller steps through three named states. **IDLE** waits for a request. The transition *accept* goes to ISSUE, or goes straight to FINISH when the mask is empty. **ISSUE** performs one pass per cycle. It stays in ISSUE while lanes are still pending, and the transition *drain* goes to FINISH once the last pending lane has been served. **FINISH** holds the per-lane read data, the valid mask and the pass count for one cycle, then *release* returns to IDLE. The bank array is a plain register array with an asynchronous read. Its per-bank enables, rows and write data are also brought out on the ports.

Top module: `bank_serializer`

## Requirements
- R1: A lane's bank is bits [4:0] of its word index and its row is bits [9:5]. In a pass, the served bank's bit of `bank_en` is set and its 5-bit field in `bank_row` (field b at bits [5b+4:5b]) carries that row.
- R2: `degree`, presented with `done`, equals the maximum over banks of the number of distinct word indices requested by active lanes in that bank.
- R3: Active lanes that read the identical word are served together in one pass and all receive that word's value.
- R4: Distinct words in the same bank go to separate passes. With lane i using index stride·i (mod 1024), strides 1, 3 and 33 take 1 pass, stride 2 takes 2, stride 4 takes 4 and stride 32 takes 32.
- R5: In each pass, every bank serves the word of its lowest-numbered pending lane.
- R6: When several active lanes write the same word, the data of the highest-numbered of those lanes is stored.
- R7: `busy` is high for exactly `degree` cycles, starting in the cycle after acceptance. It is followed by a one-cycle `done` with `busy` low. In that cycle `rd_valid` equals the request mask for reads and is zero for writes.
- R8: Inactive lanes take no part in pass selection and return zero in `rd_data`. An all-zero mask completes with `degree` 0 and no busy cycle. `rd_valid` is zero whenever `done` is low.
- R9: After reset `busy`, `done`, `bank_en`, `rd_valid` and `degree` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | LANES | Active lane mask |
| req_idx | input | LANES*IDX_W | Word index per lane, lane l at [l*IDX_W +: IDX_W] |
| req_wdata | input | LANES*DW | Write data per lane |
| busy | output | 1 | High during passes |
| done | output | 1 | One-cycle completion pulse |
| degree | output | $clog2(LANES+1) | Pass count of the last request |
| rd_valid | output | LANES | Lanes holding read data, valid with done |
| rd_data | output | LANES*DW | Read data per lane, valid with done |
| bank_en | output | BANKS | Bank served in the current pass |
| bank_wr | output | 1 | Current pass writes |
| bank_row | output | BANKS*ROW_W | Row per bank in the current pass |
| bank_wdata | output | BANKS*DW | Write data per bank in the current pass |

## Verification
A wrong pending mask or a wrong leader choice shows up at the first `done` as a wrong `degree`, and as a busy run of the wrong length. A lane that is never cleared keeps ISSUE running until the bench watchdog expires. A misrouted bank read, or a wrong write merge, appears as a wrong lane value in `rd_data` when the affected word is read back. A wrong bank or row mapping is visible on `bank_en` and `bank_row` in the first busy cycle, one cycle after the request is taken.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_IDLE   = 2'd0,
        SB_ISSUE  = 2'd1,
        SB_FINISH = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_pass_select.sv
module sb_pass_select #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int IDX_W = 10,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = IDX_W - BANK_W
) (
    input  logic [LANES-1:0]       pend,
    input  logic [LANES*IDX_W-1:0] idx,
    input  logic [LANES*DW-1:0]    wdata,
    output logic [LANES-1:0]       served,
    output logic [BANKS-1:0]       sel_en,
    output logic [BANKS*ROW_W-1:0] sel_row,
    output logic [BANKS*DW-1:0]    sel_wd
);
    logic [IDX_W-1:0] word [LANES];
    logic [LANES-1:0] lead;

    always_comb begin
        for (int l = 0; l < LANES; l++) word[l] = idx[l*IDX_W +: IDX_W];
    end

    // a lane leads its bank when no lower pending lane shares the bank
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lead[l] = pend[l];
            for (int j = 0; j < l; j++) begin
                if (pend[j] && word[j][BANK_W-1:0] == word[l][BANK_W-1:0]) lead[l] = 1'b0;
            end
        end
    end

    // a lane is served when a leader asks for the very same word
    always_comb begin
        served = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int k = 0; k < LANES; k++) begin
                if (pend[l] && lead[k] && word[k] == word[l]) served[l] = 1'b1;
            end
        end
    end

    always_comb begin
        sel_en  = '0;
        sel_row = '0;
        sel_wd  = '0;
        for (int b = 0; b < BANKS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (word[l][BANK_W-1:0] == BANK_W'(b)) begin
                    if (lead[l]) begin
                        sel_en[b] = 1'b1;
                        sel_row[b*ROW_W +: ROW_W] = word[l][IDX_W-1:BANK_W];
                    end
                    // ascending scan: the highest served lane wins the merge
                    if (served[l]) sel_wd[b*DW +: DW] = wdata[l*DW +: DW];
                end
            end
        end
    end
endmodule

// File: rtl/sb_bank_array.sv
module sb_bank_array #(
    parameter int BANKS = 32,
    parameter int ROW_W = 5,
    parameter int DW    = 32,
    localparam int ROWS = 2 ** ROW_W
) (
    input  logic                   clk,
    input  logic [BANKS-1:0]       wr_en,
    input  logic [BANKS*ROW_W-1:0] row,
    input  logic [BANKS*DW-1:0]    wd,
    output logic [BANKS*DW-1:0]    rq
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];
        always_ff @(posedge clk) begin
            if (wr_en[b]) mem[row[b*ROW_W +: ROW_W]] <= wd[b*DW +: DW];
        end
        assign rq[b*DW +: DW] = mem[row[b*ROW_W +: ROW_W]];
    end
endmodule

// File: rtl/bank_serializer.sv
module bank_serializer #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int IDX_W = 10,
    parameter int DW    = 32,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W  = IDX_W - BANK_W,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [LANES-1:0]       req_mask,
    input  logic [LANES*IDX_W-1:0] req_idx,
    input  logic [LANES*DW-1:0]    req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [CNT_W-1:0]       degree,
    output logic [LANES-1:0]       rd_valid,
    output logic [LANES*DW-1:0]    rd_data,
    output logic [BANKS-1:0]       bank_en,
    output logic                   bank_wr,
    output logic [BANKS*ROW_W-1:0] bank_row,
    output logic [BANKS*DW-1:0]    bank_wdata
);
    import sb_pkg::*;

    sb_state_e state_q, state_d;
    logic                   write_q;
    logic [LANES-1:0]       mask_q, pend_q, served;
    logic [LANES*IDX_W-1:0] idx_q;
    logic [LANES*DW-1:0]    wd_q, rd_q;
    logic [CNT_W-1:0]       pass_q;
    logic [BANKS-1:0]       sel_en;
    logic [BANKS*DW-1:0]    bank_rq;

    sb_pass_select #(.LANES(LANES), .BANKS(BANKS), .IDX_W(IDX_W), .DW(DW)) u_select (
        .pend    (pend_q),
        .idx     (idx_q),
        .wdata   (wd_q),
        .served  (served),
        .sel_en  (sel_en),
        .sel_row (bank_row),
        .sel_wd  (bank_wdata)
    );

    sb_bank_array #(.BANKS(BANKS), .ROW_W(ROW_W), .DW(DW)) u_array (
        .clk   (clk),
        .wr_en (bank_en & {BANKS{write_q}}),
        .row   (bank_row),
        .wd    (bank_wdata),
        .rq    (bank_rq)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_IDLE:   if (req_valid) state_d = (req_mask == '0) ? SB_FINISH : SB_ISSUE; // accept
            SB_ISSUE:  if ((pend_q & ~served) == '0) state_d = SB_FINISH;                // drain
            SB_FINISH: state_d = SB_IDLE;                                                 // release
            default:   state_d = SB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            mask_q  <= '0;
            pend_q  <= '0;
            idx_q   <= '0;
            wd_q    <= '0;
            rd_q    <= '0;
            pass_q  <= '0;
        end else if (state_q == SB_IDLE && req_valid) begin
            write_q <= req_write;
            mask_q  <= req_mask;
            pend_q  <= req_mask;
            idx_q   <= req_idx;
            wd_q    <= req_wdata;
            rd_q    <= '0;
            pass_q  <= '0;
        end else if (state_q == SB_ISSUE) begin
            pend_q <= pend_q & ~served;
            pass_q <= pass_q + 1'b1;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !write_q)
                    rd_q[l*DW +: DW] <= bank_rq[idx_q[l*IDX_W +: BANK_W]*DW +: DW];
            end
        end
    end

    always_comb begin
        busy     = (state_q == SB_ISSUE);
        done     = (state_q == SB_FINISH);
        degree   = pass_q;
        bank_en  = busy ? sel_en : '0;
        bank_wr  = busy && write_q;
        rd_valid = (done && !write_q) ? mask_q : '0;
        rd_data  = done ? rd_q : '0;
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] degree,
    input logic [LANES-1:0] rd_valid,
    input logic [BANKS-1:0] bank_en
);
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                 // R7
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);          // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                    // R7
    AST_PASS_SERVES: assert property (@(posedge clk) disable iff (!rst_n) busy |-> bank_en != '0);           // R2
    AST_IDLE_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> bank_en == '0);         // R1
    AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) !done |-> rd_valid == '0);     // R8
    AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) done |-> degree <= CNT_W'(LANES)); // R2
endmodule

bind bank_serializer sb_checker #(.LANES(LANES), .BANKS(BANKS)) u_sb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .degree   (degree),
    .rd_valid (rd_valid),
    .bank_en  (bank_en)
);

// File: tb/bank_serializer_bench.sv
module bank_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int L = 32;
    localparam int NW = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [L-1:0] req_mask = '0;
    logic [L*10-1:0] req_idx = '0;
    logic [L*32-1:0] req_wdata = '0;
    logic busy, done, bank_wr;
    logic [5:0] degree;
    logic [L-1:0] rd_valid;
    logic [L*32-1:0] rd_data, bank_wdata;
    logic [31:0] bank_en;
    logic [32*5-1:0] bank_row;

    bank_serializer u_bank_serializer (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    logic [9:0]  t_idx [L];
    logic [31:0] t_wd  [L];
    logic [31:0] t_mask;
    logic        t_write;
    logic [31:0] model [NW];
    logic [31:0] f_en;
    logic [32*5-1:0] f_row;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h0001_0003) ^ 32'h5A5A_0000;
    endfunction

    function automatic int exp_degree();
        int best = 0;
        for (int b = 0; b < 32; b++) begin
            int cnt = 0;
            for (int l = 0; l < L; l++) begin
                if (t_mask[l] && int'(t_idx[l] % 32) == b) begin
                    bit seen = 0;
                    for (int j = 0; j < l; j++)
                        if (t_mask[j] && t_idx[j] == t_idx[l]) seen = 1;
                    if (!seen) cnt++;
                end
            end
            if (cnt > best) best = cnt;
        end
        return best;
    endfunction

    task automatic run_access(input string tag);
        int ed, cyc, guard, bad;
        logic [31:0] exp_v, act_v, exp_d [L];
        ed = exp_degree();
        for (int l = 0; l < L; l++) exp_d[l] = (!t_write && t_mask[l]) ? model[t_idx[l]] : 32'h0;
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            req_idx[l*10 +: 10]   = t_idx[l];
            req_wdata[l*32 +: 32] = t_wd[l];
        end
        req_mask = t_mask; req_write = t_write; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        f_en = bank_en; f_row = bank_row;
        cyc = 0; guard = 0;
        while (!done && guard < 100) begin
            if (busy) cyc++;
            @(negedge clk);
            guard++;
        end
        chk(degree == 6'(ed), {tag, " R2 degree"}, 64'(degree), 64'(ed));
        chk(cyc == ed && !busy, {tag, " R7 busy length"}, 64'(cyc), 64'(ed));
        exp_v = t_write ? 32'h0 : t_mask;
        chk(rd_valid == exp_v, {tag, " R7 R8 rd_valid"}, 64'(rd_valid), 64'(exp_v));
        bad = -1;
        for (int l = L - 1; l >= 0; l--) if (rd_data[l*32 +: 32] != exp_d[l]) bad = l;
        act_v = (bad >= 0) ? rd_data[bad*32 +: 32] : 32'h0;
        chk(bad < 0, {tag, " R3 R8 rd_data"}, 64'(act_v), (bad >= 0) ? 64'(exp_d[bad]) : 64'h0);
        if (t_write)
            for (int l = 0; l < L; l++) if (t_mask[l]) model[t_idx[l]] = t_wd[l];
    endtask

    task automatic set_stride(input int stride, input logic wr);
        for (int l = 0; l < L; l++) begin
            t_idx[l] = 10'((stride * l) % NW);
            t_wd[l]  = pat(int'(t_idx[l]));
        end
        t_mask = '1; t_write = wr;
    endtask

    task automatic test_reset();
        chk(!busy && !done && bank_en == '0 && rd_valid == '0 && degree == '0, "R9 reset state",
            {32'(busy), 32'(done)}, 64'h0);
    endtask

    task automatic test_fill();
        for (int base = 0; base < NW; base += L) begin
            for (int l = 0; l < L; l++) begin
                t_idx[l] = 10'(base + l);
                t_wd[l]  = pat(base + l);
            end
            t_mask = '1; t_write = 1'b1;
            run_access("R4 fill stride 1");
        end
    endtask

    task automatic test_strides();
        set_stride(1, 0);  run_access("R4 stride 1");
        set_stride(2, 0);  run_access("R4 stride 2");
        set_stride(3, 0);  run_access("R4 stride 3");
        set_stride(4, 0);  run_access("R4 stride 4");
        set_stride(32, 0); run_access("R4 stride 32");
        set_stride(33, 0); run_access("R4 stride 33");
    endtask

    task automatic test_broadcast();
        for (int l = 0; l < L; l++) begin t_idx[l] = 10'd77; t_wd[l] = '0; end
        t_mask = '1; t_write = 1'b0;
        run_access("R3 all lanes one word");
        for (int l = 0; l < L; l++) t_idx[l] = (l < 8) ? 10'd5 : ((l == 8) ? 10'd37 : 10'd9);
        run_access("R2 R3 mixed broadcast and conflict");
    endtask

    task automatic test_order();
        for (int l = 0; l < L; l++) begin t_idx[l] = 10'd0; t_wd[l] = '0; end
        t_idx[3] = 10'd64; t_idx[10] = 10'd0;
        t_mask = 32'h0000_0408; t_write = 1'b0;
        run_access("R5 two rows in bank 0");
        chk(f_en == 32'h1 && f_row[4:0] == 5'd2, "R5 lowest lane first", {32'(f_en), 32'(f_row[4:0])}, {32'h1, 32'd2});
    endtask

    task automatic test_mapping();
        for (int l = 0; l < L; l++) begin t_idx[l] = 10'd0; t_wd[l] = '0; end
        t_idx[5] = 10'h2A7; t_mask = 32'h20; t_write = 1'b0;
        run_access("R1 single lane");
        chk(f_en == 32'h80 && f_row[7*5 +: 5] == 5'h15, "R1 bank and row", {32'(f_en), 32'(f_row[7*5 +: 5])}, {32'h80, 32'h15});
    endtask

    task automatic test_inactive();
        set_stride(32, 0);
        t_mask = 32'h0000_0003;
        run_access("R8 two lanes of stride 32");
        t_mask = '0;
        run_access("R8 empty mask");
    endtask

    task automatic test_write_merge();
        for (int l = 0; l < L; l++) begin t_idx[l] = 10'd100; t_wd[l] = 32'hAB00_0000 | 32'(l); end
        t_mask = '1; t_write = 1'b1;
        run_access("R6 all lanes write one word");
        for (int l = 0; l < L; l++) t_idx[l] = 10'd300;
        t_idx[2] = 10'd200; t_idx[5] = 10'd200;
        t_wd[2] = 32'h1111_2222; t_wd[5] = 32'h3333_4444;
        t_mask = 32'h0000_0024;
        run_access("R6 two lanes write one word");
        t_idx[0] = 10'd100; t_idx[1] = 10'd200;
        t_mask = 32'h3; t_write = 1'b0;
        run_access("R6 read back merged words");
        chk(rd_data[31:0] == 32'hAB00_001F && rd_data[63:32] == 32'h3333_4444, "R6 highest lane kept",
            {rd_data[63:32], rd_data[31:0]}, {32'h3333_4444, 32'hAB00_001F});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL R7 watchdog expired actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fill();
        test_strides();
        test_broadcast();
        test_order();
        test_mapping();
        test_inactive();
        test_write_merge();
        set_stride(2, 1); run_access("R4 stride 2 write");
        set_stride(2, 0); run_access("R4 stride 2 read back");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule